// File: doc/BRIEF.md
# Boost Window Predictor

This block watches a stream of per-cycle timing-error counts from a systolic multiply-accumulate array while an operation runs. At a fixed early cycle it compares the error total seen so far with the total seen up to half that point. From that ratio it decides whether the error profile over the whole operation looks bell-shaped, triangular, or too flat to be worth acting on. If the profile is bell-shaped or triangular, it then balances two running error areas against each other, one cycle at a time, to find where the peak-error window sits. It reports that window as a low and a high cycle, together with a flag that enables a supply boost.

The array dimension is a parameter, so all cycle marks are fixed at elaboration. The whole operation lasts TOTAL = 3*DIM-2 cycles and its mean is MEAN = TOTAL/2, rounded down. The initial marks are HIGH0 = 4*MEAN/3, LOW0 = 2*MEAN/3, TH0 = MEAN/3 and HALF0 = TH0/2, each rounded down. With DIM = 16 these are 46, 23, 30, 15, 7 and 3. The ratio thresholds and the balancing coefficients are inputs in unsigned Q8.8. Every ratio test is done by cross-multiplication, so the block has no divider.

A start pulse opens an operation. After it, one count is presented per valid cycle, together with its cycle index, counting up from 0. The window outputs stay fixed once they are resolved, until the next start.

Top module: `boost_window_predictor`

## Requirements
- R1: After reset, and on the cycle after a start pulse, boost_en_o is 0, low_o is LOW0 (15) and high_o is HIGH0 (30).
- R2: When the sample with cycle_i = TH0 arrives, let A_th be the sum of counts over cycles 0..TH0 and A_h the sum over cycles 0..HALF0. If 256*A_th > bell_thr_i*A_h, boost_en_o becomes 1 on the next cycle and bell_coef_i is taken as the balance coefficient.
- R3: If instead bell_thr_i*A_h > 256*A_th > tri_thr_i*A_h, boost_en_o becomes 1 and low_o becomes TH0. The threshold mark moves to HALF0 and tri_coef_i is taken as the balance coefficient.
- R4: In every other case, equality with a threshold included, boost_en_o stays 0 and low_o and high_o keep their initial values.
- R5: With th the threshold mark and low the low mark, the balance check runs when the sample with cycle_i = low+1 arrives. If 256*(sum of counts over th..low) < coef*(sum of counts over 0..th), both marks advance by one and the check repeats on the next cycle.
- R6: Otherwise high_o becomes low + 2*(low - th), and low_o keeps its value.
- R7: high_o is clamped to TOTAL-1 and never exceeds it.
- R8: A balance check taken on the sample with cycle_i = TOTAL-1 always resolves the window, as in R6, whatever the areas.
- R9: Once the window is resolved, or boosting has been ruled out, further valid samples have no effect on any output until the next start. boost_en_o falls only after a start.
- R10: boost_en_o rises only on the cycle after the sample with cycle_i = TH0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new operation |
| cnt_vld_i | input | 1 | A count sample is present |
| cycle_i | input | IDX_W | Operational cycle of the sample |
| err_cnt_i | input | CNT_W | Error count for that cycle |
| bell_thr_i | input | Q_W | Bell curve-factor threshold, Q8.8 |
| tri_thr_i | input | Q_W | Triangle curve-factor threshold, Q8.8 |
| bell_coef_i | input | Q_W | Balance coefficient for the bell model, Q8.8 |
| tri_coef_i | input | Q_W | Balance coefficient for the triangle model, Q8.8 |
| boost_en_o | output | 1 | Boost enable |
| low_o | output | IDX_W | Lower boundary cycle of the window |
| high_o | output | IDX_W | Upper boundary cycle of the window |

## Verification
A steep, doubling profile selects the bell model, and a linear ramp selects the triangle model. Each of them resolves after a different number of balance steps, so both the mode choice and the mark shifting can be told apart. A flat profile whose ratio sits exactly on a threshold, and an all-zero profile, show that a tie does not count as exceeding a threshold and that boosting stays off. A front-loaded profile drives the balance check out to the last cycle and so exposes the clamp. Seeded random profiles with random thresholds and coefficients, compared against a model in the bench that re-sums the areas directly, cover the paths in mixed orders. Random samples sent after each run show that a resolved window cannot be disturbed.

// File: rtl/bvp_pkg.sv
package bvp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_LOWACC,
    ST_CHECK,
    ST_DONE
  } bvp_state_e;
endpackage

// File: rtl/bvp_hist.sv
module bvp_hist #(
  parameter int DEPTH  = 46,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_a_data_o = '0;
    rd_b_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_a_idx_i == IDX_W'(i)) rd_a_data_o = mem_q[i];
      if (rd_b_idx_i == IDX_W'(i)) rd_b_data_o = mem_q[i];
    end
  end
endmodule

// File: rtl/bvp_xcmp.sv
// Ratio test without division: num/den vs q (fixed point, FRAC bits).
module bvp_xcmp #(
  parameter int AREA_W = 22,
  parameter int Q_W    = 16,
  parameter int FRAC   = 8,
  parameter bit LESS   = 1'b0
) (
  input  logic [AREA_W-1:0] num_i,
  input  logic [AREA_W-1:0] den_i,
  input  logic [Q_W-1:0]    q_i,
  output logic              hit_o
);
  localparam int P_W = AREA_W + Q_W;

  logic [P_W-1:0] lhs, rhs;

  assign lhs = P_W'(num_i) << FRAC;
  assign rhs = P_W'(q_i) * P_W'(den_i);

  if (LESS) begin : g_lt
    assign hit_o = lhs < rhs;
  end else begin : g_gt
    assign hit_o = lhs > rhs;
  end
endmodule

// File: rtl/boost_window_predictor.sv
module boost_window_predictor
  import bvp_pkg::*;
#(
  parameter int DIM   = 16,
  parameter int CNT_W = 16,
  parameter int Q_W   = 16,
  localparam int TOTAL = 3 * DIM - 2,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cnt_vld_i,
  input  logic [IDX_W-1:0] cycle_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic [Q_W-1:0]   bell_thr_i,
  input  logic [Q_W-1:0]   tri_thr_i,
  input  logic [Q_W-1:0]   bell_coef_i,
  input  logic [Q_W-1:0]   tri_coef_i,
  output logic             boost_en_o,
  output logic [IDX_W-1:0] low_o,
  output logic [IDX_W-1:0] high_o
);
  localparam int LAST   = TOTAL - 1;
  localparam int MEAN   = TOTAL / 2;
  localparam int HIGH0  = (MEAN * 4) / 3;
  localparam int LOW0   = (MEAN * 2) / 3;
  localparam int TH0    = MEAN / 3;
  localparam int HALF0  = TH0 / 2;
  localparam int FRAC   = Q_W / 2;
  localparam int AREA_W = CNT_W + IDX_W;

  bvp_state_e        state_q;
  logic [IDX_W-1:0]  th_q, low_q, high_q;
  logic [AREA_W-1:0] area_half_q, area_th_q, area_low_q;
  logic [Q_W-1:0]    coef_q;
  logic              en_q;

  logic [AREA_W-1:0] cnt_ext, ath_now, ah_now;
  logic [CNT_W-1:0]  rd_a_data, rd_b_data;
  logic [IDX_W-1:0]  rd_a_idx, low_nxt;
  logic [IDX_W+1:0]  hi_wide;
  logic [IDX_W-1:0]  hi_clamp;
  logic              bell_gt, bell_lt, tri_gt, bal_lt;
  logic              at_th, at_chk, done_w;

  assign cnt_ext = AREA_W'(err_cnt_i);
  assign ath_now = area_th_q + ((cycle_i <= th_q) ? cnt_ext : '0);
  assign ah_now  = area_half_q + ((cycle_i <= IDX_W'(HALF0)) ? cnt_ext : '0);
  assign low_nxt = low_q + 1'b1;
  assign at_th   = cycle_i == th_q;
  assign at_chk  = cycle_i == low_nxt;
  assign rd_a_idx = (state_q == ST_ACQ) ? IDX_W'(HALF0) : th_q + 1'b1;

  assign hi_wide  = {2'b00, low_q} + (({2'b00, low_q} - {2'b00, th_q}) << 1);
  assign hi_clamp = (hi_wide > (IDX_W+2)'(LAST)) ? IDX_W'(LAST) : hi_wide[IDX_W-1:0];
  assign done_w   = state_q == ST_DONE;

  bvp_hist #(.DEPTH(TOTAL), .DATA_W(CNT_W), .IDX_W(IDX_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cnt_vld_i),
    .wr_idx_i    (cycle_i),
    .wr_data_i   (err_cnt_i),
    .rd_a_idx_i  (rd_a_idx),
    .rd_a_data_o (rd_a_data),
    .rd_b_idx_i  (th_q),
    .rd_b_data_o (rd_b_data)
  );

  bvp_xcmp #(.AREA_W(AREA_W), .Q_W(Q_W), .FRAC(FRAC), .LESS(1'b0)) u_bell_gt (
    .num_i(ath_now), .den_i(ah_now), .q_i(bell_thr_i), .hit_o(bell_gt));
  bvp_xcmp #(.AREA_W(AREA_W), .Q_W(Q_W), .FRAC(FRAC), .LESS(1'b1)) u_bell_lt (
    .num_i(ath_now), .den_i(ah_now), .q_i(bell_thr_i), .hit_o(bell_lt));
  bvp_xcmp #(.AREA_W(AREA_W), .Q_W(Q_W), .FRAC(FRAC), .LESS(1'b0)) u_tri_gt (
    .num_i(ath_now), .den_i(ah_now), .q_i(tri_thr_i), .hit_o(tri_gt));
  bvp_xcmp #(.AREA_W(AREA_W), .Q_W(Q_W), .FRAC(FRAC), .LESS(1'b1)) u_bal_lt (
    .num_i(area_low_q), .den_i(area_th_q), .q_i(coef_q), .hit_o(bal_lt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      th_q        <= IDX_W'(TH0);
      low_q       <= IDX_W'(LOW0);
      high_q      <= IDX_W'(HIGH0);
      area_half_q <= '0;
      area_th_q   <= '0;
      area_low_q  <= '0;
      coef_q      <= '0;
      en_q        <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_ACQ;
      th_q        <= IDX_W'(TH0);
      low_q       <= IDX_W'(LOW0);
      high_q      <= IDX_W'(HIGH0);
      area_half_q <= '0;
      area_th_q   <= '0;
      area_low_q  <= '0;
      coef_q      <= '0;
      en_q        <= 1'b0;
    end else if (cnt_vld_i) begin
      unique case (state_q)
        ST_ACQ: begin
          area_half_q <= ah_now;
          area_th_q   <= ath_now;
          if (at_th) begin
            if (bell_gt) begin
              en_q       <= 1'b1;
              coef_q     <= bell_coef_i;
              area_low_q <= cnt_ext;
              state_q    <= ST_LOWACC;
            end else if (bell_lt && tri_gt) begin
              // triangle: look earlier, low <- old th, th <- half
              en_q       <= 1'b1;
              coef_q     <= tri_coef_i;
              low_q      <= th_q;
              th_q       <= IDX_W'(HALF0);
              area_th_q  <= ah_now;
              area_low_q <= ath_now - ah_now + AREA_W'(rd_a_data);
              state_q    <= ST_CHECK;
            end else begin
              state_q    <= ST_DONE;
            end
          end
        end
        ST_LOWACC: begin
          if (cycle_i <= low_q) area_low_q <= area_low_q + cnt_ext;
          if (cycle_i == low_q) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (at_chk) begin
            if (bal_lt && cycle_i != IDX_W'(LAST)) begin
              th_q       <= th_q + 1'b1;
              low_q      <= low_nxt;
              area_th_q  <= area_th_q + AREA_W'(rd_a_data);
              area_low_q <= area_low_q - AREA_W'(rd_b_data) + cnt_ext;
            end else begin
              high_q  <= hi_clamp;
              state_q <= ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign boost_en_o = en_q;
  assign low_o      = low_q;
  assign high_o     = high_q;
endmodule

// File: rtl/bvp_chk.sv
module bvp_chk #(
  parameter int DIM = 16,
  localparam int TOTAL = 3 * DIM - 2,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cnt_vld_i,
  input logic [IDX_W-1:0] cycle_i,
  input logic             boost_en_o,
  input logic [IDX_W-1:0] low_o,
  input logic [IDX_W-1:0] high_o,
  input logic             done_i
);
  localparam int LAST = TOTAL - 1;
  localparam int TH0  = (TOTAL / 2) / 3;

  AST_EN_RISE_AT_TH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boost_en_o) |-> $past(cnt_vld_i) && $past(cycle_i) == IDX_W'(TH0)); // R10
  AST_EN_FALL_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boost_en_o) |-> $past(start_i)); // R9
  AST_HIGH_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_o <= IDX_W'(LAST)); // R7
  AST_LOW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(low_o) |-> $past(start_i) || low_o == IDX_W'(TH0)
                        || low_o == IDX_W'($past(low_o) + 1'b1)); // R5
  AST_HIGH_AT_RESOLVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(high_o) |-> $past(start_i) || $rose(done_i)); // R6
  AST_WINDOW_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && boost_en_o |-> low_o <= high_o); // R6
endmodule

bind boost_window_predictor bvp_chk #(.DIM(DIM)) u_bvp_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cnt_vld_i  (cnt_vld_i),
  .cycle_i    (cycle_i),
  .boost_en_o (boost_en_o),
  .low_o      (low_o),
  .high_o     (high_o),
  .done_i     (done_w)
);

// File: tb/boost_window_predictor_tb_top.sv
`timescale 1ns/1ps
module boost_window_predictor_tb_top;
  localparam int DIM   = 16;
  localparam int TOTAL = 3 * DIM - 2;
  localparam int LAST  = TOTAL - 1;
  localparam int MEAN  = TOTAL / 2;
  localparam int HIGH0 = (MEAN * 4) / 3;
  localparam int LOW0  = (MEAN * 2) / 3;
  localparam int TH0   = MEAN / 3;
  localparam int HALF0 = TH0 / 2;
  localparam int IDX_W = $clog2(TOTAL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vld = 1'b0;
  logic [IDX_W-1:0] cyc = '0;
  logic [15:0] cnt = '0;
  logic [15:0] bthr = '0, tthr = '0, bcoef = '0, tcoef = '0;
  logic boost_en;
  logic [IDX_W-1:0] low, high;

  int n_chk = 0;
  int n_bad = 0;
  int prof [TOTAL];

  always #2.5 clk = ~clk;

  boost_window_predictor #(.DIM(DIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cnt_vld_i(vld),
    .cycle_i(cyc), .err_cnt_i(cnt), .bell_thr_i(bthr), .tri_thr_i(tthr),
    .bell_coef_i(bcoef), .tri_coef_i(tcoef),
    .boost_en_o(boost_en), .low_o(low), .high_o(high));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint psum(input int a, input int b);
    longint s = 0;
    for (int i = a; i <= b; i++) s += prof[i];
    return s;
  endfunction

  // mode: 0 off, 1 bell, 2 triangle
  task automatic model(output int mode, output int e_low, output int e_high,
                       output bit clamped, output bit hit_last);
    longint ath = psum(0, TH0);
    longint ah  = psum(0, HALF0);
    int th, lo, hv;
    longint coef;
    clamped = 0; hit_last = 0;
    if (ath * 256 > longint'(bthr) * ah) begin
      mode = 1; th = TH0; lo = LOW0; coef = bcoef;
    end else if (ath * 256 < longint'(bthr) * ah && ath * 256 > longint'(tthr) * ah) begin
      mode = 2; th = HALF0; lo = TH0; coef = tcoef;
    end else begin
      mode = 0; e_low = LOW0; e_high = HIGH0;
      return;
    end
    while (psum(th, lo) * 256 < coef * psum(0, th) && lo + 1 < LAST) begin
      th++; lo++;
    end
    hit_last = (lo + 1 == LAST);
    hv = lo + 2 * (lo - th);
    clamped = hv > LAST;
    e_low = lo;
    e_high = clamped ? LAST : hv;
  endtask

  task automatic run(input string tag);
    int mode, el, eh;
    bit cl, hl;
    string rq;
    model(mode, el, eh, cl, hl);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({"R1 en after start ", tag}, int'(boost_en), 0);
    chk({"R1 low after start ", tag}, int'(low), LOW0);
    chk({"R1 high after start ", tag}, int'(high), HIGH0);
    for (int k = 0; k < TOTAL; k++) begin
      vld = 1'b1; cyc = IDX_W'(k); cnt = 16'(prof[k]);
      @(negedge clk);
      if (k == TH0) begin
        rq = (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
        chk({rq, " en at threshold ", tag}, int'(boost_en), (mode != 0) ? 1 : 0);
      end
    end
    vld = 1'b0;
    rq = (mode == 0) ? "R4" : hl ? "R8" : "R5";
    chk({rq, " final en ", tag}, int'(boost_en), (mode != 0) ? 1 : 0);
    chk({rq, " final low ", tag}, int'(low), el);
    rq = (mode == 0) ? "R4" : cl ? "R7" : "R6";
    chk({rq, " final high ", tag}, int'(high), eh);
    for (int j = 0; j < 4; j++) begin
      vld = 1'b1; cyc = IDX_W'($urandom_range(0, LAST)); cnt = 16'($urandom);
      @(negedge clk);
    end
    vld = 1'b0;
    chk({"R9 en kept ", tag}, int'(boost_en), (mode != 0) ? 1 : 0);
    chk({"R9 low kept ", tag}, int'(low), el);
    chk({"R9 high kept ", tag}, int'(high), eh);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R1 reset en", int'(boost_en), 0);
    chk("R1 reset low", int'(low), LOW0);
    chk("R1 reset high", int'(high), HIGH0);
    rst_n = 1'b1;
    @(negedge clk);

    // steep doubling profile: bell
    for (int k = 0; k < TOTAL; k++) prof[k] = (k <= MEAN) ? (1 << (k / 3)) : (1 << ((TOTAL - k) / 3));
    bthr = 16'd768; tthr = 16'd256; bcoef = 16'd512; tcoef = 16'd256;
    run("bell");

    // linear ramp: triangle
    for (int k = 0; k < TOTAL; k++) prof[k] = 10 * ((k <= MEAN) ? k : TOTAL - k);
    bthr = 16'd1536; tthr = 16'd512; bcoef = 16'd256; tcoef = 16'd384;
    run("triangle");

    // flat, ratio equals triangle threshold: off (R4 tie)
    for (int k = 0; k < TOTAL; k++) prof[k] = 5;
    bthr = 16'd768; tthr = 16'd512;
    run("tie_tri");

    // flat, ratio equals bell threshold: off
    bthr = 16'd512; tthr = 16'd256;
    run("tie_bell");

    // all zero: off
    for (int k = 0; k < TOTAL; k++) prof[k] = 0;
    run("zero");

    // front-loaded: balance runs to last cycle, clamp (R7, R8)
    for (int k = 0; k < TOTAL; k++) prof[k] = (k < 4) ? 10 : (k < 8) ? 30 : 0;
    bthr = 16'd1280; tthr = 16'd512; bcoef = 16'd256; tcoef = 16'd1024;
    run("clamp");

    for (int r = 0; r < 40; r++) begin
      int peak = $urandom_range(4, TOTAL - 4);
      int sh = $urandom_range(0, 3);
      for (int k = 0; k < TOTAL; k++) begin
        int d = (k > peak) ? k - peak : peak - k;
        prof[k] = (sh == 0) ? int'($urandom_range(0, 200))
                            : ((d < 12) ? ((12 - d) ** sh) : 0) + int'($urandom_range(0, 3));
      end
      bthr  = 16'($urandom_range(256, 2048));
      tthr  = 16'($urandom_range(0, 768));
      bcoef = 16'($urandom_range(64, 1024));
      tcoef = 16'($urandom_range(64, 1024));
      run($sformatf("rand%0d", r));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule